// File: doc/BRIEF.md
# Event Counting Performance Monitor

This block counts activity inside a processor core. It has one cycle counter and two general counters. Each general counter follows one event line, and an 8-bit code in the control word picks that line. Software reaches four 32-bit registers through a small port with a 2-bit address and a write strobe. Reads are combinational from the address.

All three counters advance only while a single global enable is set. No counter has an enable of its own. To stop one general counter, software points its code at a value that never fires. When a counter wraps, it sets a sticky overflow flag. Software clears a flag by writing a one to it. A single shared interrupt is raised while any flag is set and its interrupt enable is set.

The event lines are single-cycle pulses, one bit per event code. The cycle counter can run undivided, or it can advance once every 64 enabled clocks.

Top module: `perf_event_monitor`

## Requirements
- R1: After reset, all four registers read 0 and `irq_o` is low.
- R2: Address 0 is the control word, 1 the cycle counter, 2 general counter A and 3 general counter B. Every register can be written, and the counter registers read back the value written. A counter write on the same edge as an increment of that counter stores the written value.
- R3: While control bit 0 (global enable) is 0, no counter changes except through a register write or a reset bit.
- R4: The cycle counter gains 1 on every clock where the global enable is set. When control bit 3 is set, it instead gains 1 once per 64 enabled clocks, on the 64th enabled clock after its prescaler was last cleared. The prescaler is cleared by reset and by the cycle-counter reset bit.
- R5: Counter A's code is control bits 27:20 and counter B's code is bits 19:12. An enabled counter gains 1 on each clock where `event_i[code]` is high for codes 0x00 to 0x12. Code 0xFF counts every clock. Every other code, including 0x20, never counts.
- R6: Writing control bit 1 as 1 clears both general counters. Writing bit 2 as 1 clears the cycle counter and its prescaler. Either clear overrides an increment on the same edge, and bits 1 and 2 always read 0.
- R7: When a counter steps from 0xFFFFFFFF to 0, its flag sets on that same edge. The flags are bit 8 for counter A, bit 9 for counter B and bit 10 for the cycle counter.
- R8: Flags are sticky. A control write with a 1 in a flag bit clears that flag, and a 0 leaves it unchanged. A wrap on the same edge as the clearing write leaves the flag set.
- R9: `irq_o` is high exactly when some flag is set together with its enable. The enables are bit 4 for counter A, bit 5 for counter B and bit 6 for the cycle counter.
- R10: Writing back a control value just read changes nothing except clearing the flags that were set. All other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 2 | Register select |
| bus_wr_i | input | 1 | Write strobe, one write per high cycle |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| event_i | input | 19 | Event pulses, bit n is event code n |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
Two pairs of functions can land on the same edge.

- **Wrap and flag clear.** A counter wrap can coincide with a control write that clears the flag of that same counter. To provoke this, the bench preloads counter B near 0xFFFFFFFF with code 0xFF, so the wrap falls on a known edge, and issues the write-one-clear on exactly that edge. The flag must then read 1.
- **Write and increment.** A counter write can coincide with an increment, and a reset bit can coincide with an increment. Both cases are judged against a behavioural model that applies the write or clear in place of the increment, and compares the addressed register and the interrupt every clock.

// File: rtl/perf_mon_pkg.sv
// perf_mon_pkg: shared constants for the event counting performance monitor.
// Assumes a 32-bit register port; bit positions are fixed by software usage.
package perf_mon_pkg;

    localparam int DATA_W     = 32;

    // control word bit positions
    localparam int CB_ENABLE  = 0;
    localparam int CB_CLR_GEN = 1;
    localparam int CB_CLR_CYC = 2;
    localparam int CB_DIVIDE  = 3;
    localparam int CB_IE_LSB  = 4;   // 3 enables: A, B, cycle
    localparam int CB_OV_LSB  = 8;   // 3 flags:   A, B, cycle
    localparam int CB_SELA_LSB = 20;
    localparam int CB_SELB_LSB = 12;

    // counter slot numbering, matches enable/flag order
    localparam int SLOT_A     = 0;
    localparam int SLOT_B     = 1;
    localparam int SLOT_CYC   = 2;
    localparam int NUM_SLOTS  = 3;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_CYCLE = 2'd1,
        REG_GEN_A = 2'd2,
        REG_GEN_B = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/perf_event_select.sv
// perf_event_select: turns an event code into a per-clock count request.
// Assumes codes below NUM_EVT index event_i, the all-ones code means every
// clock, and every other code never fires (used to park a counter).
module perf_event_select #(
    parameter int SEL_W   = 8,
    parameter int NUM_EVT = 19
) (
    input  logic [SEL_W-1:0]   code_i,
    input  logic [NUM_EVT-1:0] event_i,
    output logic               hit_o
);
    localparam int SPACE = 1 << SEL_W;

    logic [SPACE-1:0] padded;

    // widen the event vector to the full code space, unused codes are 0
    always_comb begin
        padded = '0;
        padded[NUM_EVT-1:0] = event_i;
    end

    // pick the selected line, with the all-ones code meaning every clock
    always_comb begin
        if (&code_i) hit_o = 1'b1;
        else         hit_o = padded[code_i];
    end

endmodule

// File: rtl/perf_prescaler.sv
// perf_prescaler: divide-by-2**DIV_LOG2 tick source for the cycle counter.
// Assumes run_i is the global enable; clr_i restarts the division period.
module perf_prescaler #(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic tick_o
);
    logic [DIV_LOG2-1:0] pre_q;

    // advance the divider on every enabled clock, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) pre_q <= '0;
        else if (run_i)      pre_q <= pre_q + 1'b1;
    end

    // the last enabled clock of each period produces the tick
    assign tick_o = run_i && (&pre_q);

    AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pre_q == '0)); // R4

endmodule

// File: rtl/perf_counter.sv
// perf_counter: one loadable wrapping counter with a wrap strobe.
// Assumes clr_i beats load_i beats inc_i; wrap_o only on a real increment.
module perf_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    // clear, load, or step the count value
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (load_i)     cnt_q <= load_val_i;
        else if (inc_i)      cnt_q <= cnt_q + 1'b1;
    end

    // a step taken from all-ones is a wrap
    assign wrap_o = inc_i && !load_i && !clr_i && (&cnt_q);
    assign cnt_o  = cnt_q;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0)); // R7
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i) |=> (cnt_q == $past(load_val_i))); // R2
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/perf_event_monitor.sv
// perf_event_monitor: control word, three counters, read mux and interrupt.
// Assumes one register access per cycle; reads are combinational from the
// address, and a write takes effect on the clock edge where bus_wr_i is high.
module perf_event_monitor
    import perf_mon_pkg::*;
#(
    parameter int NUM_EVT  = 19,
    parameter int SEL_W    = 8,
    parameter int DIV_LOG2 = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    input  logic [NUM_EVT-1:0] event_i,
    output logic               irq_o
);
    localparam logic [SEL_W-1:0] PARK_CODE = SEL_W'(8'h20);

    logic                 en_q, div_q;
    logic [NUM_SLOTS-1:0] ie_q, ovf_q;
    logic [SEL_W-1:0]     sel_q [2];
    logic                 ctrl_wr, clr_gen, clr_cyc, pre_tick;
    logic [NUM_SLOTS-1:0] inc_v, clr_v, load_v, wrap_v;
    logic [DATA_W-1:0]    cnt_v [NUM_SLOTS];

    assign ctrl_wr = bus_wr_i && (bus_addr_i == REG_CTRL);
    assign clr_gen = ctrl_wr && bus_wdata_i[CB_CLR_GEN];
    assign clr_cyc = ctrl_wr && bus_wdata_i[CB_CLR_CYC];

    // control fields, written whole on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            div_q    <= 1'b0;
            ie_q     <= '0;
            sel_q[0] <= '0;
            sel_q[1] <= '0;
        end else if (ctrl_wr) begin
            en_q     <= bus_wdata_i[CB_ENABLE];
            div_q    <= bus_wdata_i[CB_DIVIDE];
            ie_q     <= bus_wdata_i[CB_IE_LSB +: NUM_SLOTS];
            sel_q[0] <= bus_wdata_i[CB_SELA_LSB +: SEL_W];
            sel_q[1] <= bus_wdata_i[CB_SELB_LSB +: SEL_W];
        end
    end

    // sticky flags: write-one clears, a wrap on the same edge still sets
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= '0;
        else if (ctrl_wr)
            ovf_q <= (ovf_q & ~bus_wdata_i[CB_OV_LSB +: NUM_SLOTS]) | wrap_v;
        else
            ovf_q <= ovf_q | wrap_v;
    end

    perf_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_cyc), .run_i(en_q), .tick_o(pre_tick)
    );

    // one counter per slot; general slots get an event selector
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        if (i == SLOT_CYC) begin : g_cyc
            assign inc_v[i]  = en_q && (!div_q || pre_tick);
            assign clr_v[i]  = clr_cyc;
            assign load_v[i] = bus_wr_i && (bus_addr_i == REG_CYCLE);
        end else begin : g_gen
            logic hit;
            perf_event_select #(.SEL_W(SEL_W), .NUM_EVT(NUM_EVT)) u_sel (
                .code_i(sel_q[i]), .event_i(event_i), .hit_o(hit)
            );
            assign inc_v[i]  = en_q && hit;
            assign clr_v[i]  = clr_gen;
            assign load_v[i] = bus_wr_i &&
                (bus_addr_i == ((i == SLOT_A) ? REG_GEN_A : REG_GEN_B));

            AST_PARKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_q[i] == PARK_CODE && !load_v[i] && !clr_v[i])
                |=> $stable(cnt_v[i])); // R5
        end

        perf_counter #(.W(DATA_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr_i(clr_v[i]), .load_i(load_v[i]),
            .load_val_i(bus_wdata_i), .inc_i(inc_v[i]),
            .cnt_o(cnt_v[i]), .wrap_o(wrap_v[i])
        );

        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_q && !load_v[i] && !clr_v[i]) |=> $stable(cnt_v[i])); // R3
        AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            wrap_v[i] |=> ovf_q[i]); // R7
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf_q[i] && !(ctrl_wr && bus_wdata_i[CB_OV_LSB + i])) |=> ovf_q[i]); // R8
    end

    // read mux; reset bits and unused positions read as zero
    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            REG_CTRL: begin
                bus_rdata_o[CB_ENABLE]                 = en_q;
                bus_rdata_o[CB_DIVIDE]                 = div_q;
                bus_rdata_o[CB_IE_LSB +: NUM_SLOTS]    = ie_q;
                bus_rdata_o[CB_OV_LSB +: NUM_SLOTS]    = ovf_q;
                bus_rdata_o[CB_SELA_LSB +: SEL_W]      = sel_q[0];
                bus_rdata_o[CB_SELB_LSB +: SEL_W]      = sel_q[1];
            end
            REG_CYCLE: bus_rdata_o = cnt_v[SLOT_CYC];
            REG_GEN_A: bus_rdata_o = cnt_v[SLOT_A];
            default:   bus_rdata_o = cnt_v[SLOT_B];
        endcase
    end

    // single shared interrupt
    assign irq_o = |(ovf_q & ie_q);

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ovf_q != '0 && ie_q != '0)); // R9

endmodule

// File: tb/perf_event_monitor_bench.sv
`timescale 1ns/1ps
// perf_event_monitor_bench: behavioural reference model compared every clock.
module perf_event_monitor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [18:0] evt = '0;
    logic        irq;

    always #2 clk = ~clk;  // 250 MHz

    perf_event_monitor u_perf_event_monitor (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .event_i(evt), .irq_o(irq)
    );

    int compared = 0;
    int mismatched = 0;

    // reference state
    bit        m_en, m_div;
    bit [2:0]  m_ie, m_ovf;
    bit [7:0]  m_sa, m_sb;
    bit [31:0] m_cyc, m_a, m_b;
    int        m_pre;
    bit [31:0] rng = 32'h1234_5678;

    function automatic bit hit(bit [7:0] code, bit [18:0] ev);
        if (code == 8'hFF) return 1'b1;
        if (code <= 8'h12) return ev[code];
        return 1'b0;
    endfunction

    function automatic bit [31:0] m_read(bit [1:0] a);
        case (a)
            2'd0: return {4'b0, m_sa, m_sb, 1'b0, m_ovf, 1'b0, m_ie, m_div, 2'b00, m_en};
            2'd1: return m_cyc;
            2'd2: return m_a;
            default: return m_b;
        endcase
    endfunction

    function automatic bit [31:0] cw(bit en, bit div, bit [2:0] ie, bit [7:0] sa,
                                     bit [7:0] sb, bit [2:0] clrf, bit rg, bit rc);
        return {4'b0, sa, sb, 1'b0, clrf, 1'b0, ie, div, rc, rg, en};
    endfunction

    task automatic m_reset();
        m_en = 0; m_div = 0; m_ie = 0; m_ovf = 0; m_sa = 0; m_sb = 0;
        m_cyc = 0; m_a = 0; m_b = 0; m_pre = 0;
    endtask

    // one clock edge of the reference model
    task automatic m_edge(bit [1:0] a, bit we, bit [31:0] wd, bit [18:0] ev);
        bit cw_hit, ia, ib, ic, wa, wb, wc;
        cw_hit = we && (a == 2'd0);
        ia = m_en && hit(m_sa, ev);
        ib = m_en && hit(m_sb, ev);
        ic = m_en && (!m_div || m_pre == 63);
        wa = 0; wb = 0; wc = 0;
        if (cw_hit && wd[1]) begin m_a = 0; m_b = 0; end
        else begin
            if (we && a == 2'd2) m_a = wd; else if (ia) begin wa = (m_a == '1); m_a++; end
            if (we && a == 2'd3) m_b = wd; else if (ib) begin wb = (m_b == '1); m_b++; end
        end
        if (cw_hit && wd[2]) begin m_cyc = 0; m_pre = 0; end
        else begin
            if (we && a == 2'd1) m_cyc = wd; else if (ic) begin wc = (m_cyc == '1); m_cyc++; end
            if (m_en) m_pre = (m_pre + 1) % 64;
        end
        if (cw_hit) m_ovf = m_ovf & ~wd[10:8];
        m_ovf = m_ovf | {wc, wb, wa};
        if (cw_hit) begin
            m_en = wd[0]; m_div = wd[3]; m_ie = wd[6:4]; m_sa = wd[27:20]; m_sb = wd[19:12];
        end
    endtask

    task automatic check(string tag);
        bit [31:0] er;
        bit ei;
        er = m_read(addr);
        ei = |(m_ovf & m_ie);
        compared++;
        if (rdata !== er) begin
            mismatched++;
            $display("FAIL %s: addr %0d rdata actual %h expected %h", tag, addr, rdata, er);
        end
        compared++;
        if (irq !== ei) begin
            mismatched++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, ei);
        end
    endtask

    // drive one cycle, advance the model at the edge, compare at the falling edge
    task automatic step(bit [1:0] a, bit we, bit [31:0] wd, bit [18:0] ev, string tag);
        addr = a; wr = we; wdata = wd; evt = ev;
        @(posedge clk);
        m_edge(a, we, wd, ev);
        @(negedge clk);
        check(tag);
    endtask

    function automatic bit [18:0] next_evt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng[18:0];
    endfunction

    task automatic idle(int n, bit [1:0] a, bit rnd, string tag);
        for (int k = 0; k < n; k++) step(a, 1'b0, '0, rnd ? next_evt() : '0, tag);
    endtask

    initial begin
        #(4 * 150000);
        mismatched++;
        $display("FAIL watchdog: run actual hung, expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1");
        // R1: reset values at every address
        for (int a = 0; a < 4; a++) idle(1, a[1:0], 1'b0, "R1");

        // R2: counters load and read back, R3: nothing moves while disabled
        step(2'd2, 1, 32'h0000_0005, '0, "R2");
        step(2'd3, 1, 32'hA5A5_0001, '0, "R2");
        step(2'd1, 1, 32'd100, '0, "R2");
        idle(4, 2'd1, 1'b1, "R3");
        idle(4, 2'd2, 1'b1, "R3");

        // R5 and R4: event A on code 0x03, B every clock, cycle undivided
        step(2'd0, 1, cw(1, 0, 3'b111, 8'h03, 8'hFF, 0, 0, 0), '0, "R5");
        for (int k = 0; k < 40; k++) step(2'(k % 4), 0, '0, next_evt(), "R5");
        step(2'd0, 1, cw(1, 0, 3'b111, 8'h11, 8'h07, 0, 0, 0), '0, "R5");
        for (int k = 0; k < 24; k++) step(2'(k % 4), 0, '0, next_evt(), "R4");

        // R2: write to a counting counter overrides the increment
        step(2'd0, 1, cw(1, 0, 3'b111, 8'hFF, 8'hFF, 0, 0, 0), '0, "R2");
        step(2'd3, 1, 32'h0000_0040, '1, "R2");
        idle(2, 2'd3, 1'b1, "R2");

        // R5: parked code 0x20 and out-of-range code 0x13 never count
        step(2'd0, 1, cw(1, 0, 3'b111, 8'h20, 8'h13, 0, 0, 0), '0, "R5");
        idle(6, 2'd2, 1'b1, "R5");
        step(2'd0, 1, cw(1, 0, 3'b111, 8'h20, 8'h13, 0, 0, 0), '1, "R5");
        for (int k = 0; k < 6; k++) step(2'd3, 0, '0, '1, "R5");

        // R7 and R9: counter B wraps, flag 9 and interrupt follow
        step(2'd0, 1, cw(1, 0, 3'b111, 8'h20, 8'hFF, 0, 0, 0), '0, "R7");
        step(2'd3, 1, 32'hFFFF_FFFD, '0, "R7");
        idle(4, 2'd0, 1'b0, "R7");
        idle(1, 2'd3, 1'b0, "R9");

        // R10: write back the read value, only the flag clears
        step(2'd0, 1, m_read(2'd0), '0, "R10");
        idle(3, 2'd0, 1'b0, "R10");
        idle(1, 2'd3, 1'b0, "R10");

        // R8: wrap and clear of flag 9 on the same edge
        step(2'd3, 1, 32'hFFFF_FFFE, '0, "R8");
        idle(1, 2'd0, 1'b0, "R8");
        step(2'd0, 1, cw(1, 0, 3'b111, 8'h20, 8'hFF, 3'b010, 0, 0), '0, "R8");
        idle(2, 2'd0, 1'b0, "R8");
        step(2'd0, 1, cw(1, 0, 3'b111, 8'h20, 8'hFF, 3'b000, 0, 0), '0, "R8");
        idle(1, 2'd0, 1'b0, "R8");

        // R9: masking the enable drops the interrupt, flag stays
        step(2'd0, 1, cw(1, 0, 3'b101, 8'h20, 8'hFF, 0, 0, 0), '0, "R9");
        idle(2, 2'd0, 1'b0, "R9");
        step(2'd0, 1, cw(1, 0, 3'b111, 8'h20, 8'hFF, 3'b111, 0, 0), '0, "R9");

        // R6: reset bits clear counters, override increments, read as zero
        step(2'd0, 1, cw(1, 0, 3'b111, 8'hFF, 8'hFF, 0, 1, 0), '1, "R6");
        idle(1, 2'd2, 1'b0, "R6");
        idle(1, 2'd1, 1'b0, "R6");
        step(2'd0, 1, cw(1, 0, 3'b111, 8'hFF, 8'hFF, 0, 0, 1), '1, "R6");
        idle(1, 2'd1, 1'b0, "R6");

        // R4: divided cycle count, prescaler restarted by the cycle reset
        step(2'd0, 1, cw(1, 1, 3'b111, 8'h20, 8'h20, 0, 0, 1), '0, "R4");
        idle(200, 2'd1, 1'b0, "R4");
        step(2'd0, 1, cw(1, 1, 3'b111, 8'h20, 8'h20, 0, 0, 1), '0, "R4");
        idle(70, 2'd1, 1'b0, "R4");

        // R7: cycle counter wrap sets flag 10
        step(2'd0, 1, cw(1, 0, 3'b111, 8'h20, 8'h20, 0, 0, 0), '0, "R7");
        step(2'd1, 1, 32'hFFFF_FFFE, '0, "R7");
        idle(3, 2'd0, 1'b0, "R7");

        // R3: global disable freezes every counter
        step(2'd0, 1, cw(0, 0, 3'b111, 8'hFF, 8'hFF, 0, 0, 0), '1, "R3");
        for (int k = 0; k < 12; k++) step(2'(k % 4), 0, '0, next_evt(), "R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule